// File: doc/BRIEF.md
# Cycle-Stealing Block Transfer Channel

This block moves a run of 16-bit words between one peripheral and a word-addressed memory in which every word carries a protect bit. The processor starts a transfer with a single start pulse. That pulse loads a first address, an end address, a direction and a privilege flag. After that the channel works on its own. Each time it needs memory it raises a request. It uses the memory only in a cycle where the processor has granted it, which means the processor has not started a read of its own. In that cycle the channel holds the processor for one cycle and performs one read or one write. The processor then continues.

The address counter steps after every stolen cycle and is compared against the end address. When they match, the channel goes idle and pulses a completion interrupt. The counter can be read at any time to follow progress. Words sent out are given an odd parity bit. Words coming in have their odd parity checked unless checking is inhibited. A transfer without privilege cannot overwrite a protected word. Such a word is dropped, and the transfer carries on. The channel has no path that could change any protect bit. On the input side a single holding register takes one device word and back-pressures the device until that word has been stored.

Top module: `dma_steal_chan`

## Requirements
- R1: Out of reset, busy, mem_req, cpu_hold, mem_we, dev_in_ready, dev_out_valid and all three interrupt outputs are low.
- R2: A start pulse while busy is low loads the addresses, direction and privilege, and raises busy. A start pulse while busy is high is ignored, so the running transfer ends at its own end address. busy is high while a transfer is active or an output word still waits for the device.
- R3: A memory cycle is stolen only in a cycle where mem_req and mem_gnt are both high. cpu_hold is high in exactly that cycle. While mem_gnt is low, mem_req stays high and cur_addr does not move.
- R4: cur_addr rises by one after each stolen cycle. After the steal whose incremented address equals the end address, the channel goes idle and irq_done is high for one cycle. The transfer therefore covers the start address up to the end address minus one.
- R5: With dir_out=1 (memory to device), each word read at cur_addr is presented on dev_out_data in address order, with dev_out_par chosen so that data and parity bit together hold an odd number of ones. The word is held until dev_out_ready is high.
- R6: With dir_out=0, an accepted input word whose data and parity bit hold an even number of ones pulses irq_parity the cycle after acceptance, unless par_inhibit is high. The word is stored anyway.
- R7: With dir_out=0 and priv=0, a word aimed at an address whose mem_rprot is 1 is not written, and the transfer continues. irq_protect pulses for that word if pv_irq_sel is 1. With priv=1, protected words are written. The memory port carries no protect-bit write.
- R8: While an input word is held waiting for a steal, dev_in_ready is low and the held word does not change.
- R9: cur_addr shows the address of the next word at any time during a transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low reset |
| start | input | 1 | start pulse from the processor |
| start_addr | input | 15 | first word address |
| final_addr | input | 15 | end address (one past the last word) |
| dir_out | input | 1 | 1 = memory to device, 0 = device to memory |
| priv | input | 1 | transfer may write protected words |
| par_inhibit | input | 1 | disables the input parity check |
| pv_irq_sel | input | 1 | selects the protect-violation interrupt |
| busy | output | 1 | transfer active or output word pending |
| cur_addr | output | 15 | current address counter |
| mem_req | output | 1 | channel wants a memory cycle |
| mem_gnt | input | 1 | processor has not begun its own read this cycle |
| cpu_hold | output | 1 | processor suspended for a stolen cycle |
| mem_addr | output | 15 | memory address |
| mem_we | output | 1 | memory write strobe |
| mem_wdata | output | 16 | memory write data |
| mem_rdata | input | 16 | memory read data, same cycle |
| mem_rprot | input | 1 | protect bit of the addressed word, same cycle |
| dev_in_valid | input | 1 | device offers an input word |
| dev_in_data | input | 16 | input word |
| dev_in_par | input | 1 | input parity bit |
| dev_in_ready | output | 1 | channel takes an input word |
| dev_out_valid | output | 1 | output word available |
| dev_out_data | output | 16 | output word |
| dev_out_par | output | 1 | output parity bit |
| dev_out_ready | input | 1 | device takes the output word |
| irq_done | output | 1 | completion interrupt pulse |
| irq_parity | output | 1 | input parity error interrupt pulse |
| irq_protect | output | 1 | protect violation interrupt pulse |

## Verification
A steal takes effect at the clock edge that ends the granted cycle. cur_addr, an output word and a memory write are therefore visible from the next cycle. irq_done, irq_parity and irq_protect are one-cycle pulses in the cycle after the steal or acceptance that causes them. The bench drives all inputs one time unit after a rising edge and samples on the falling edge, so every value it reads is the one the next rising edge uses. Output words go through a queue filled at start and drained by a monitor on each falling-edge handshake. Memory contents and interrupt counts are compared only after busy has fallen and the pulses have had a cycle to appear.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;
  parameter int WORD_W = 16;
  parameter int ADDR_W = 15;
  typedef logic [WORD_W-1:0] word_t;
  typedef logic [ADDR_W-1:0] addr_t;

  // odd parity bit for an outgoing word
  function automatic logic odd_par_bit(input word_t d);
    return ~(^d);
  endfunction

  // 1 when word plus parity bit hold an odd number of ones
  function automatic logic odd_par_ok(input word_t d, input logic p);
    return ^{p, d};
  endfunction

  function automatic addr_t addr_step(input addr_t a);
    return a + addr_t'(1);
  endfunction
endpackage

// File: rtl/dma_addr_unit.sv
module dma_addr_unit
  import dma_chan_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  load,
  input  addr_t ld_start,
  input  addr_t ld_final,
  input  logic  step,
  output addr_t cur,
  output logic  active,
  output logic  done
);
  addr_t fin_q;
  addr_t nxt;
  logic  hit;

  assign nxt = addr_step(cur);
  assign hit = (nxt == fin_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur    <= '0;
      fin_q  <= '0;
      active <= 1'b0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (load) begin
        cur    <= ld_start;
        fin_q  <= ld_final;
        active <= 1'b1;
      end else if (step) begin
        cur <= nxt;
        if (hit) begin
          active <= 1'b0;
          done   <= 1'b1;
        end
      end
    end
  end

  // R3: a steal only happens while a transfer is active
  a_r3_step_when_active: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> active);
  // R3: counter holds without a steal or a load
  a_r3_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !step) |=> $stable(cur));
  // R4: counter moves by exactly one per steal
  a_r4_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load) |=> cur == addr_step($past(cur)));
  // R4: completion leaves the channel idle
  a_r4_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !active);
endmodule

// File: rtl/dma_in_path.sv
module dma_in_path
  import dma_chan_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  en,
  input  logic  par_inhibit,
  input  logic  priv,
  input  logic  pv_sel,
  input  logic  dev_in_valid,
  input  word_t dev_in_data,
  input  logic  dev_in_par,
  output logic  dev_in_ready,
  output logic  hold_valid,
  output word_t hold_data,
  input  logic  steal,
  input  logic  mem_rprot,
  output logic  mem_we,
  output logic  irq_parity,
  output logic  irq_protect
);
  logic accept, steal_in, wr_ok;

  assign dev_in_ready = en && !hold_valid;
  assign accept       = dev_in_valid && dev_in_ready;
  assign steal_in     = steal && hold_valid;
  assign wr_ok        = priv || !mem_rprot;
  assign mem_we       = steal_in && wr_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_valid  <= 1'b0;
      hold_data   <= '0;
      irq_parity  <= 1'b0;
      irq_protect <= 1'b0;
    end else begin
      irq_parity  <= accept && !par_inhibit && !odd_par_ok(dev_in_data, dev_in_par);
      irq_protect <= steal_in && !wr_ok && pv_sel;
      if (accept) begin
        hold_valid <= 1'b1;
        hold_data  <= dev_in_data;
      end else if (steal_in) begin
        hold_valid <= 1'b0;
      end
    end
  end

  // R8: a held word stays put until its steal
  a_r8_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_valid && !steal) |=> hold_valid && $stable(hold_data));
  // R8: device is back-pressured while the register is full
  a_r8_backpressure: assert property (@(posedge clk) disable iff (!rst_n)
    hold_valid |-> !dev_in_ready);
endmodule

// File: rtl/dma_out_path.sv
module dma_out_path
  import dma_chan_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  en,
  input  logic  steal,
  input  word_t mem_rdata,
  input  logic  dev_out_ready,
  output logic  out_valid,
  output word_t out_data,
  output logic  out_par,
  output logic  need
);
  assign need = en && !out_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_par   <= 1'b0;
    end else if (steal && need) begin
      out_valid <= 1'b1;
      out_data  <= mem_rdata;
      out_par   <= odd_par_bit(mem_rdata);
    end else if (out_valid && dev_out_ready) begin
      out_valid <= 1'b0;
    end
  end

  // R5: an offered word is held until the device takes it
  a_r5_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !dev_out_ready) |=> out_valid && $stable(out_data) && $stable(out_par));
  // R5: presented word carries odd parity
  a_r5_out_parity: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> odd_par_ok(out_data, out_par));
endmodule

// File: rtl/dma_steal_chan.sv
module dma_steal_chan
  import dma_chan_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [ADDR_W-1:0] final_addr,
  input  logic              dir_out,
  input  logic              priv,
  input  logic              par_inhibit,
  input  logic              pv_irq_sel,
  output logic              busy,
  output logic [ADDR_W-1:0] cur_addr,
  output logic              mem_req,
  input  logic              mem_gnt,
  output logic              cpu_hold,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_we,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic [WORD_W-1:0] mem_rdata,
  input  logic              mem_rprot,
  input  logic              dev_in_valid,
  input  logic [WORD_W-1:0] dev_in_data,
  input  logic              dev_in_par,
  output logic              dev_in_ready,
  output logic              dev_out_valid,
  output logic [WORD_W-1:0] dev_out_data,
  output logic              dev_out_par,
  input  logic              dev_out_ready,
  output logic              irq_done,
  output logic              irq_parity,
  output logic              irq_protect
);
  logic  active, start_acc, steal, dir_q, priv_q;
  logic  hold_valid, out_need;
  addr_t cur;
  word_t hold_data;

  assign start_acc = start && !busy;
  assign busy      = active || dev_out_valid;
  assign mem_req   = hold_valid || out_need;
  assign steal     = mem_req && mem_gnt;
  assign cpu_hold  = steal;
  assign cur_addr  = cur;
  assign mem_addr  = cur;
  assign mem_wdata = hold_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q  <= 1'b0;
      priv_q <= 1'b0;
    end else if (start_acc) begin
      dir_q  <= dir_out;
      priv_q <= priv;
    end
  end

  dma_addr_unit u_addr (
    .clk(clk), .rst_n(rst_n), .load(start_acc),
    .ld_start(start_addr), .ld_final(final_addr),
    .step(steal), .cur(cur), .active(active), .done(irq_done)
  );

  dma_in_path u_in (
    .clk(clk), .rst_n(rst_n), .en(active && !dir_q),
    .par_inhibit(par_inhibit), .priv(priv_q), .pv_sel(pv_irq_sel),
    .dev_in_valid(dev_in_valid), .dev_in_data(dev_in_data), .dev_in_par(dev_in_par),
    .dev_in_ready(dev_in_ready), .hold_valid(hold_valid), .hold_data(hold_data),
    .steal(steal), .mem_rprot(mem_rprot), .mem_we(mem_we),
    .irq_parity(irq_parity), .irq_protect(irq_protect)
  );

  dma_out_path u_out (
    .clk(clk), .rst_n(rst_n), .en(active && dir_q), .steal(steal),
    .mem_rdata(mem_rdata), .dev_out_ready(dev_out_ready),
    .out_valid(dev_out_valid), .out_data(dev_out_data), .out_par(dev_out_par),
    .need(out_need)
  );

  // R2: start during a transfer leaves the latched mode alone
  a_r2_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (start && busy) |=> $stable(dir_q) && $stable(priv_q));
  // R3: an ungranted request persists
  a_r3_req_persist: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_gnt) |=> mem_req);
  // R7: no write lands on a protected word without privilege
  a_r7_protect_guard: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (priv_q || !mem_rprot) && !dir_q && mem_gnt);
  // R6: interrupts stay quiet while idle in the other direction
  a_r6_parity_only_input: assert property (@(posedge clk) disable iff (!rst_n)
    irq_parity |-> !dir_q);
endmodule

// File: tb/dma_steal_chan_bench.sv
module dma_steal_chan_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 0, dir_out = 0, priv = 0, par_inhibit = 0, pv_irq_sel = 0;
  logic [14:0] start_addr = '0, final_addr = '0;
  logic busy, mem_req, cpu_hold, mem_we, mem_rprot, mem_gnt = 0;
  logic [14:0] cur_addr, mem_addr;
  logic [15:0] mem_wdata, mem_rdata;
  logic dev_in_valid = 0, dev_in_par = 0, dev_in_ready;
  logic [15:0] dev_in_data = '0;
  logic dev_out_valid, dev_out_par, dev_out_ready = 0;
  logic [15:0] dev_out_data;
  logic irq_done, irq_parity, irq_protect;

  always #2 clk = ~clk;

  dma_steal_chan u_dma_steal_chan (.*);

  logic [15:0] mem [64];
  logic        prot [64];
  logic [15:0] exp_mem [64];
  assign mem_rdata = mem[mem_addr[5:0]];
  assign mem_rprot = prot[mem_addr[5:0]];
  always @(posedge clk) if (mem_we) mem[mem_addr[5:0]] <= mem_wdata;

  int checks = 0, errors = 0, cyc = 0;
  int n_done = 0, n_par = 0, n_prot = 0;
  int gnt_mode = 0, rdy_mode = 0;
  logic [16:0] exp_q[$];
  bit finished = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // drive grant and device ready one unit after each rising edge
  always @(posedge clk) begin
    cyc <= cyc + 1;
    #1;
    mem_gnt       = (gnt_mode == 0) || (gnt_mode == 1 && cyc[0]);
    dev_out_ready = (rdy_mode == 0) || (rdy_mode == 1 && (cyc % 3 != 0));
  end

  // monitor: interrupt counts and output scoreboard at falling edges
  always @(negedge clk) begin
    if (rst_n) begin
      if (irq_done) n_done++;
      if (irq_parity) n_par++;
      if (irq_protect) n_prot++;
      if (dev_out_valid && dev_out_ready) begin
        if (exp_q.size() == 0) check(0, "R5 unexpected word", dev_out_data, 0);
        else begin
          logic [16:0] e;
          e = exp_q.pop_front();
          check({dev_out_par, dev_out_data} == e, "R5 output word", {dev_out_par, dev_out_data}, e);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual hung expected idle");
    finish_run();
  end

  task automatic do_start(input int sa, input int fa, input bit d, input bit p);
    @(posedge clk); #1;
    start_addr = 15'(sa); final_addr = 15'(fa); dir_out = d; priv = p; start = 1;
    @(posedge clk); #1;
    start = 0;
  endtask

  task automatic push_out(input int sa, input int fa);
    for (int a = sa; a < fa; a++) exp_q.push_back({~(^mem[a]), mem[a]});
  endtask

  task automatic send_word(input logic [15:0] d, input bit bad);
    @(posedge clk); #1;
    dev_in_valid = 1; dev_in_data = d; dev_in_par = (~(^d)) ^ bad;
    forever begin
      @(negedge clk);
      if (dev_in_ready) break;
    end
    @(posedge clk); #1;
    dev_in_valid = 0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic check_mem(input int sa, input int fa, input string req);
    for (int a = sa; a < fa; a++) check(mem[a] == exp_mem[a], req, mem[a], exp_mem[a]);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) begin
      mem[i] = 16'h1000 + 16'(i * 16'h0137);
      prot[i] = (i == 13 || i == 15 || i == 21);
      exp_mem[i] = mem[i];
    end
    repeat (3) @(negedge clk);
    // R1 reset state
    check(!busy && !mem_req && !cpu_hold && !mem_we, "R1 idle", {busy, mem_req, cpu_hold, mem_we}, 0);
    check(!dev_in_ready && !dev_out_valid && !irq_done && !irq_parity && !irq_protect,
          "R1 quiet", {dev_in_ready, dev_out_valid, irq_done, irq_parity, irq_protect}, 0);
    @(posedge clk); #1 rst_n = 1;

    // output transfer 4..9 with toggling grant and a gapped device
    gnt_mode = 1; rdy_mode = 1;
    push_out(4, 10);
    do_start(4, 10, 1, 0);
    wait_idle();
    check(exp_q.size() == 0, "R5 all words delivered", exp_q.size(), 0);
    check(n_done == 1, "R4 one done pulse", n_done, 1);
    check(cur_addr == 15'd10, "R4 stops at end address", cur_addr, 10);

    // grant withheld: request waits, counter still; then progress and ignored start
    gnt_mode = 2; rdy_mode = 0;
    push_out(30, 38);
    do_start(30, 38, 1, 0);
    repeat (4) @(negedge clk);
    check(mem_req && !cpu_hold, "R3 request waits for grant", {mem_req, cpu_hold}, 2);
    check(cur_addr == 15'd30, "R3 counter holds without grant", cur_addr, 30);
    gnt_mode = 1;
    repeat (6) @(negedge clk);
    check(busy && cur_addr > 15'd30 && cur_addr < 15'd38, "R9 progress readable", cur_addr, 34);
    do_start(50, 52, 0, 1);
    wait_idle();
    check(cur_addr == 15'd38, "R2 start while busy ignored", cur_addr, 38);
    check(n_done == 2 && exp_q.size() == 0, "R2 original transfer completed", n_done, 2);

    // input, no privilege, violation interrupt selected; 13 and 15 protected
    gnt_mode = 0; pv_irq_sel = 1;
    do_start(12, 18, 0, 0);
    for (int a = 12; a < 18; a++) begin
      send_word(16'hA000 + 16'(a), 0);
      if (!prot[a]) exp_mem[a] = 16'hA000 + 16'(a);
    end
    wait_idle();
    check_mem(12, 18, "R7 protected words kept");
    check(n_prot == 2, "R7 violation interrupts", n_prot, 2);
    check(n_done == 3, "R7 transfer continues to end", n_done, 3);

    // input with privilege: protected word 21 is written
    pv_irq_sel = 1;
    do_start(20, 23, 0, 1);
    for (int a = 20; a < 23; a++) begin
      send_word(16'hB000 + 16'(a), 0);
      exp_mem[a] = 16'hB000 + 16'(a);
    end
    wait_idle();
    check_mem(20, 23, "R7 privileged write");
    check(n_prot == 2, "R7 no violation when privileged", n_prot, 2);

    // no privilege, interrupt not selected
    pv_irq_sel = 0;
    do_start(15, 16, 0, 0);
    send_word(16'hC0DE, 0);
    wait_idle();
    check(mem[15] == exp_mem[15], "R7 word dropped silently", mem[15], exp_mem[15]);
    check(n_prot == 2, "R7 interrupt not selected", n_prot, 2);

    // back-pressure with grant withheld
    gnt_mode = 2;
    do_start(40, 42, 0, 0);
    send_word(16'h4040, 0);
    repeat (2) @(negedge clk);
    check(!dev_in_ready && mem_req, "R8 device held off", {dev_in_ready, mem_req}, 1);
    check(mem[40] == exp_mem[40], "R8 nothing written without grant", mem[40], exp_mem[40]);
    gnt_mode = 0;
    send_word(16'h4141, 0);
    exp_mem[40] = 16'h4040; exp_mem[41] = 16'h4141;
    wait_idle();
    check_mem(40, 42, "R8 held words stored in order");

    // parity error reported, then inhibited
    do_start(44, 46, 0, 0);
    send_word(16'h0F0F, 1);
    send_word(16'h1234, 0);
    exp_mem[44] = 16'h0F0F; exp_mem[45] = 16'h1234;
    wait_idle();
    check(n_par == 1, "R6 parity error interrupt", n_par, 1);
    check_mem(44, 46, "R6 word stored despite error");
    par_inhibit = 1;
    do_start(46, 47, 0, 0);
    send_word(16'h5555, 1);
    exp_mem[46] = 16'h5555;
    wait_idle();
    check(n_par == 1, "R6 inhibit suppresses check", n_par, 1);
    check(!busy && !mem_req, "R1 idle again", {busy, mem_req}, 0);
    finish_run();
  end
endmodule